// File: doc/BRIEF.md
# Three-Channel Interval Timer

This peripheral holds three independent up-counting timer channels behind one small register window. Each channel picks a count source (every core clock, or an alternate tick-enable input standing in for an external clock). It can divide that source by a power of two, count freely with a wrap at the top of its range, or count up to a programmable limit and flag an interrupt each time it wraps back to zero.

Software programs each channel through a single-cycle register bus. Registers of the same kind for the three channels sit next to each other, four bytes apart. The pending interrupt flag is cleared by reading it. Each channel drives its own level interrupt line, which is gated by an enable bit. The counter width is a parameter, 16 or 32 bits.

Top module: `tri_timer`

## Requirements
- R1: Register offsets for channel 0 are clock setup 0x00, count control 0x0C, live count 0x18, limit 0x24, pending flags 0x54 and interrupt enable 0x60. Channels 1 and 2 add 4 and 8 to these offsets. After reset, count control reads 0x21 and every other register reads 0.
- R2: Clock setup has three fields. Bit 0 enables the divider. Bits 4:1 hold a code N. Bit 5 selects the source. With the divider on, the count advances once per 2^(N+1) source ticks. With the divider off, it advances on every source tick. All six bits read back as written.
- R3: When clock setup bit 5 is 1, the source tick is the `extTick` input. When bit 5 is 0, every clock cycle is a source tick.
- R4: While count control bit 0 is 1, the count holds its value.
- R5: Writing count control with bit 4 set zeroes the count in that write's cycle. Bit 4 always reads back 0. Bits 0, 1 and 5 are stored. When a write clears bit 0 and sets bit 4 together, the channel counts from zero.
- R6: When count control bit 1 is 1 (limit mode), the count steps up to the limit, then wraps to zero on the next tick. That wrap sets pending bit 0.
- R7: When bit 1 is 0, the count wraps from 2^W-1 to 0 and sets no pending bit.
- R8: A read of the pending register returns the flag and clears it in the same cycle. If a new wrap happens in that cycle, the flag stays set.
- R9: Each `irq` bit is 1 exactly while that channel's pending bit 0 and enable bit 0 are both 1.
- R10: Writing clock setup, or resetting the count, restarts the divider. The first tick after either comes a full divide period later.
- R11: The live count register ignores bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (drives read-clear) |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| extTick | input | 1 | Alternate source tick enable, synchronous to clk |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The assertions assume a single bus master that issues at most one access per cycle. They also assume that `extTick` is already synchronous to `clk`.

Under those assumptions, the bound checker holds four properties on every channel. A disabled counter changes only on a reset write. A pending flag rises only at a wrap to zero from limit mode. It falls only after a read of its own address. An interrupt never appears without its enable.

The stimulus drives bus strobes one at a time, between clock edges. It changes `extTick` only at falling edges, and it resets a counter only while that channel is quiet. The register table and the directed timing tests therefore stay inside what the checker takes for granted.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int NUM_CH = 3;
  localparam int PRE_W  = 4;
  localparam int DIV_W  = 1 << PRE_W;

  localparam logic [7:0] OFF_CLK  = 8'h00;
  localparam logic [7:0] OFF_CNT  = 8'h0C;
  localparam logic [7:0] OFF_VAL  = 8'h18;
  localparam logic [7:0] OFF_LIM  = 8'h24;
  localparam logic [7:0] OFF_PEND = 8'h54;
  localparam logic [7:0] OFF_IEN  = 8'h60;

  typedef struct packed {
    logic             enable;
    logic             limitMode;
    logic             divOn;
    logic [PRE_W-1:0] divCode;
    logic             extSel;
    logic             cntReset;
    logic             divClear;
    logic             pendRead;
  } chanCtl_t;

  function automatic logic [7:0] chanAddr(logic [7:0] base, int ch);
    return base + 8'(4 * ch);
  endfunction
endpackage

// File: rtl/tri_timer_ctrl.sv
module tri_timer_ctrl
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              busWe,
  input  logic                              busRe,
  input  logic [7:0]                        busAddr,
  input  logic [31:0]                       busWdata,
  output logic [31:0]                       busRdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      countVal,
  input  logic [NUM_CH-1:0]                 pendVal,
  output chanCtl_t [NUM_CH-1:0]             chanCtl,
  output logic [NUM_CH-1:0][CNT_W-1:0]      limitVal,
  output logic [NUM_CH-1:0]                 ienVal
);
  localparam logic [5:0] CNT_KEEP  = 6'b10_0011;
  localparam logic [5:0] CNT_RESET = 6'h21;

  logic [NUM_CH-1:0][5:0]       clkReg;
  logic [NUM_CH-1:0][5:0]       cntReg;
  logic [NUM_CH-1:0][CNT_W-1:0] limReg;
  logic [NUM_CH-1:0]            ienReg;

  function automatic logic [31:0] widen(logic [CNT_W-1:0] v);
    logic [31:0] r;
    r = '0;
    r[CNT_W-1:0] = v;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        clkReg[c] <= '0;
        cntReg[c] <= CNT_RESET;
        limReg[c] <= '0;
        ienReg[c] <= 1'b0;
      end
    end else if (busWe) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (busAddr == chanAddr(OFF_CLK, c)) clkReg[c] <= busWdata[5:0];
        if (busAddr == chanAddr(OFF_CNT, c)) cntReg[c] <= busWdata[5:0] & CNT_KEEP;
        if (busAddr == chanAddr(OFF_LIM, c)) limReg[c] <= busWdata[CNT_W-1:0];
        if (busAddr == chanAddr(OFF_IEN, c)) ienReg[c] <= busWdata[0];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      chanCtl[c].enable    = ~cntReg[c][0];
      chanCtl[c].limitMode = cntReg[c][1];
      chanCtl[c].divOn     = clkReg[c][0];
      chanCtl[c].divCode   = clkReg[c][PRE_W:1];
      chanCtl[c].extSel    = clkReg[c][5];
      chanCtl[c].cntReset  = busWe && (busAddr == chanAddr(OFF_CNT, c)) && busWdata[4];
      chanCtl[c].divClear  = busWe && (busAddr == chanAddr(OFF_CLK, c));
      chanCtl[c].pendRead  = busRe && (busAddr == chanAddr(OFF_PEND, c));
    end
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (busAddr == chanAddr(OFF_CLK, c))  busRdata = {26'b0, clkReg[c]};
      if (busAddr == chanAddr(OFF_CNT, c))  busRdata = {26'b0, cntReg[c]};
      if (busAddr == chanAddr(OFF_VAL, c))  busRdata = widen(countVal[c]);
      if (busAddr == chanAddr(OFF_LIM, c))  busRdata = widen(limReg[c]);
      if (busAddr == chanAddr(OFF_PEND, c)) busRdata = {31'b0, pendVal[c]};
      if (busAddr == chanAddr(OFF_IEN, c))  busRdata = {31'b0, ienReg[c]};
    end
  end

  assign limitVal = limReg;
  assign ienVal   = ienReg;
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCtl_t         ctl,
  input  logic [CNT_W-1:0] limitVal,
  input  logic             extTick,
  output logic [CNT_W-1:0] countVal,
  output logic             pendVal
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic             srcTick;
  logic             divHit;
  logic             stepTick;
  logic             wrapEvt;

  assign divLimit = DIV_W'((33'd2 << ctl.divCode) - 33'd1);
  assign srcTick  = ctl.extSel ? extTick : 1'b1;
  assign divHit   = srcTick && (divCnt == divLimit);
  assign stepTick = ctl.enable && (ctl.divOn ? divHit : srcTick);
  assign wrapEvt  = stepTick && ctl.limitMode && !ctl.cntReset && (countVal == limitVal);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntReset || ctl.divClear) begin
      divCnt <= '0;
    end else if (ctl.divOn && srcTick) begin
      divCnt <= divHit ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntReset) begin
      countVal <= '0;
    end else if (stepTick) begin
      countVal <= wrapEvt ? '0 : countVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVal <= 1'b0;
    end else if (wrapEvt) begin
      pendVal <= 1'b1;
    end else if (ctl.pendRead) begin
      pendVal <= 1'b0;
    end
  end
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              extTick,
  output logic [NUM_CH-1:0] irq
);
  chanCtl_t [NUM_CH-1:0]        chanCtl;
  logic [NUM_CH-1:0][CNT_W-1:0] limitVec;
  logic [NUM_CH-1:0][CNT_W-1:0] countVec;
  logic [NUM_CH-1:0]            pendVec;
  logic [NUM_CH-1:0]            ienVec;
  logic [NUM_CH-1:0]            enableVec;
  logic [NUM_CH-1:0]            modeVec;

  tri_timer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .countVal (countVec),
    .pendVal  (pendVec),
    .chanCtl  (chanCtl),
    .limitVal (limitVec),
    .ienVal   (ienVec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tri_timer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (chanCtl[c]),
      .limitVal (limitVec[c]),
      .extTick  (extTick),
      .countVal (countVec[c]),
      .pendVal  (pendVec[c])
    );
    assign enableVec[c] = chanCtl[c].enable;
    assign modeVec[c]   = chanCtl[c].limitMode;
  end

  assign irq = pendVec & ienVec;
endmodule

// File: rtl/tri_timer_chk.sv
module tri_timer_chk
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         busWe,
  input logic                         busRe,
  input logic [7:0]                   busAddr,
  input logic                         resetBit,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0][CNT_W-1:0] countVec,
  input logic [NUM_CH-1:0]            pendVec,
  input logic [NUM_CH-1:0]            ienVec,
  input logic [NUM_CH-1:0]            enableVec,
  input logic [NUM_CH-1:0]            modeVec
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [7:0] CNT_A  = chanAddr(OFF_CNT, c);
    localparam logic [7:0] PEND_A = chanAddr(OFF_PEND, c);

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!enableVec[c] && !(busWe && busAddr == CNT_A && resetBit)) |=> $stable(countVec[c])); // R4
    AST_PEND_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendVec[c]) |-> (countVec[c] == '0 && $past(modeVec[c]))); // R6
    AST_PEND_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendVec[c]) |-> $past(busRe && busAddr == PEND_A)); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] |-> (ienVec[c] && pendVec[c])); // R9
  end
endmodule

bind tri_timer tri_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busRe     (busRe),
  .busAddr   (busAddr),
  .resetBit  (busWdata[4]),
  .irq       (irq),
  .countVec  (countVec),
  .pendVec   (pendVec),
  .ienVec    (ienVec),
  .enableVec (enableVec),
  .modeVec   (modeVec)
);

// File: tb/tri_timer_tb_top.sv
module tri_timer_tb_top;
  localparam int CNT_W = 16;
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        extTick = 1'b0;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tri_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extTick(extTick), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,    8'd1},  // R1 reset clock setup ch0
    '{1'b0, 8'h04, 32'h0,    8'd1},  // R1
    '{1'b0, 8'h08, 32'h0,    8'd1},  // R1
    '{1'b0, 8'h0C, 32'h21,   8'd1},  // R1 reset count control ch0
    '{1'b0, 8'h10, 32'h21,   8'd1},  // R1
    '{1'b0, 8'h14, 32'h21,   8'd1},  // R1
    '{1'b0, 8'h24, 32'h0,    8'd1},  // R1
    '{1'b0, 8'h54, 32'h0,    8'd1},  // R1
    '{1'b0, 8'h60, 32'h0,    8'd1},  // R1
    '{1'b1, 8'h28, 32'h1234, 8'd1},  // R1 limit ch1
    '{1'b0, 8'h28, 32'h1234, 8'd1},  // R1
    '{1'b0, 8'h24, 32'h0,    8'd1},  // R1 ch0 untouched
    '{1'b0, 8'h2C, 32'h0,    8'd1},  // R1 ch2 untouched
    '{1'b1, 8'h10, 32'h33,   8'd5},  // R5 write with reset bit
    '{1'b0, 8'h10, 32'h23,   8'd5},  // R5 bit 4 reads 0
    '{1'b1, 8'h18, 32'hFFFF, 8'd11}, // R11 write to live count
    '{1'b0, 8'h18, 32'h0,    8'd11}, // R11
    '{1'b1, 8'h04, 32'h3F,   8'd2},  // R2 all fields
    '{1'b0, 8'h04, 32'h3F,   8'd2},  // R2
    '{1'b1, 8'h04, 32'h0,    8'd2},  // R2 restore
    '{1'b0, 8'h04, 32'h0,    8'd2}   // R2
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk);
    #1 busRe = 1'b0;
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    waitEdges(3);
    @(negedge clk) rstN = 1'b1;
    #1 check("R1 irq reset", {29'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) busWrite(VECS[i].addr, VECS[i].data);
      else begin
        busRead(VECS[i].addr, rd);
        check($sformatf("R%0d table %0d", VECS[i].req, i), rd, VECS[i].data);
      end
    end

    // R5: enable and reset together, count from zero
    busWrite(8'h0C, 32'h10);
    waitEdges(5);
    busRead(8'h18, rd);
    check("R5 restart count", rd, 32'd5);

    // R4: disabled counter holds
    busWrite(8'h0C, 32'h01);
    busRead(8'h18, rd);
    waitEdges(10);
    busRead(8'h18, rd2);
    check("R4 hold while disabled", rd2, rd);

    // R2: divide by 2 then by 8
    busWrite(8'h00, 32'h01);
    busWrite(8'h0C, 32'h10);
    waitEdges(7);
    busRead(8'h18, rd);
    check("R2 divide by 2", rd, 32'd3);
    busWrite(8'h0C, 32'h01);
    busWrite(8'h00, 32'h05);
    busWrite(8'h0C, 32'h10);
    waitEdges(20);
    busRead(8'h18, rd);
    check("R2 divide by 8", rd, 32'd2);

    // R10: clock setup write restarts divider
    busWrite(8'h0C, 32'h11);
    busWrite(8'h0C, 32'h10);
    waitEdges(5);
    busWrite(8'h00, 32'h05);
    waitEdges(7);
    busRead(8'h18, rd);
    check("R10 divider restarted", rd, 32'd0);

    // R3: alternate source
    busWrite(8'h0C, 32'h01);
    busWrite(8'h00, 32'h20);
    busWrite(8'h0C, 32'h10);
    waitEdges(5);
    busRead(8'h18, rd);
    check("R3 no ext ticks", rd, 32'd0);
    @(negedge clk) extTick = 1'b1;
    waitEdges(3);
    @(negedge clk) extTick = 1'b0;
    busRead(8'h18, rd);
    check("R3 three ext ticks", rd, 32'd3);

    // R6 / R9 / R8: limit mode on channel 0
    busWrite(8'h0C, 32'h01);
    busWrite(8'h00, 32'h00);
    busWrite(8'h24, 32'd3);
    busWrite(8'h60, 32'h1);
    busWrite(8'h0C, 32'h12);
    waitEdges(3);
    @(negedge clk);
    check("R6 no flag before wrap", {29'b0, irq}, 32'h0);
    waitEdges(1);
    #1 check("R6 irq after wrap", {31'b0, irq[0]}, 32'h1);
    busRead(8'h54, rd);
    check("R8 pending read value", rd, 32'h1);
    check("R8 irq cleared by read", {31'b0, irq[0]}, 32'h0);
    busRead(8'h54, rd);
    check("R8 pending cleared", rd, 32'h0);
    busWrite(8'h0C, 32'h03);

    // R9: gating on channel 2
    busWrite(8'h2C, 32'd1);
    busWrite(8'h14, 32'h12);
    waitEdges(4);
    #1 check("R9 masked irq", {31'b0, irq[2]}, 32'h0);
    busWrite(8'h68, 32'h1);
    check("R9 irq after enable", {31'b0, irq[2]}, 32'h1);
    busWrite(8'h14, 32'h01);
    busRead(8'h5C, rd);
    check("R8 ch2 pending", rd, 32'h1);
    check("R9 irq drops", {31'b0, irq[2]}, 32'h0);

    // R7: free-running rollover without flag
    busWrite(8'h0C, 32'h10);
    waitEdges(int'(CNT_MAX));
    busRead(8'h18, rd);
    check("R7 top of range", rd, CNT_MAX);
    busRead(8'h18, rd);
    check("R7 wrapped to zero", rd, 32'h0);
    busRead(8'h54, rd);
    check("R7 no pending on rollover", rd, 32'h0);

    finish_run();
  end
endmodule